// File: doc/BRIEF.md
# Dual-Latch Output Compare Unit

This block produces four waveform pins from two external count sources. Every channel holds two compare values. The first, the set value, drives the channel's pin high when the selected count reaches it. The second, the clear value, drives the pin low. Each compare value also has its own interrupt request line, which pulses when that value matches. The timers themselves live outside the block. It sees only their count values, a running flag per timer and a one-cycle underflow strobe per timer.

Software programs the unit through a plain write bus. The bus has no ready signal, so it applies no back-pressure: every cycle with the write strobe high is taken. A compare write passes straight into the active compare latch when the channel's timer is stopped. When the timer is running, the write is parked in a buffer and reaches the latch at that timer's next underflow, so a running waveform never sees a half-updated pair of values. Each channel can have its trigger turned off. The pin then freezes, but match interrupts continue.

Top module: `ocu_top`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, every waveform pin and every interrupt line is low.
- R2: While a channel's selected timer is stopped (its run bit low), a compare write loads that channel's latch at once. The bus addresses are channel*2 for the set value and channel*2+1 for the clear value.
- R3: While the selected timer is running, a compare write changes only a buffer. The old latch value keeps matching until that timer's underflow strobe, which copies the buffer into the latch.
- R4: A compare write in the same cycle as the selected timer's underflow places the newly written value in the latch.
- R5: With the trigger enabled, a set-value match drives the pin high and a clear-value match drives it low, one clock after the cycle in which the count equals the latch.
- R6: A match is counted only on the first cycle of equality while the timer runs. Its interrupt, irq_o[2*channel+latch], is a one-cycle pulse one clock later.
- R7: The control register at address 8 holds the trigger enables in bits 7:4 (bit 4+channel). With a channel's trigger clear, its pin holds its level, while its match interrupts still fire.
- R8: The interrupt-enable register at address 9 has one bit per latch, bit 2*channel+latch. A cleared bit suppresses that interrupt, but the waveform is still updated.
- R9: A compare value that the count never reaches never matches, so the pin stays at a fixed level. The other latch of the channel still matches and interrupts.
- R10: Control bit channel (bits 3:0) selects the count source: 0 is timer 0 and 1 is timer 1. The selected timer's run bit and underflow strobe also come from that source.
- R11: If both latches of a channel match in the same cycle (equal values), the pin is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr0_cnt | input | 8 | Count value of timer 0 |
| tmr1_cnt | input | 8 | Count value of timer 1 |
| tmr_run | input | 2 | Running flag per timer, bit t for timer t |
| tmr_unf | input | 2 | One-cycle underflow strobe per timer |
| bus_we | input | 1 | Register write strobe, always accepted |
| bus_addr | input | 4 | Register address: 0-7 compare, 8 control, 9 interrupt enable |
| bus_wdata | input | 8 | Register write data |
| wave_o | output | 4 | Waveform pin per channel |
| irq_o | output | 8 | Compare-match interrupt pulse per latch |

## Verification
Two events can land in the same cycle. The first pairing is a compare write and the selected timer's underflow. The bench issues a write to a running channel's clear latch in exactly the cycle of the underflow strobe. It then confirms that the old clear value no longer matches and that the new one does. The second pairing is both latches of one channel matching together. The bench loads equal values and sweeps the count onto them. It checks that both interrupts pulse in the same cycle and that the pin stays low.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int TIMERS = 2;
  localparam int LATCHES_PER_CH = 2;
  localparam int SET_IDX = 0;
  localparam int CLR_IDX = 1;

  typedef enum logic [0:0] {
    SRC_T0 = 1'b0,
    SRC_T1 = 1'b1
  } src_e;
endpackage

// File: rtl/ocu_regs.sv
module ocu_regs #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [2*NCH-1:0]    cmp_we,
  output logic [NCH-1:0]      src_sel,
  output logic [NCH-1:0]      trig_en,
  output logic [2*NCH-1:0]    ien
);
  localparam int NSLOT     = 2 * NCH;
  localparam int ADDR_CTRL = NSLOT;
  localparam int ADDR_IEN  = NSLOT + 1;

  logic [2*NCH-1:0] ctrl_q;
  logic [NSLOT-1:0] ien_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_we
    assign cmp_we[g] = bus_we && (bus_addr == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(ADDR_CTRL)) ctrl_q <= bus_wdata[2*NCH-1:0];
      if (bus_addr == AW'(ADDR_IEN))  ien_q  <= bus_wdata[NSLOT-1:0];
    end
  end

  assign src_sel = ctrl_q[NCH-1:0];
  assign trig_en = ctrl_q[2*NCH-1:NCH];
  assign ien     = ien_q;
endmodule

// File: rtl/ocu_slot.sv
module ocu_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          run,
  input  logic          unf,
  input  logic [DW-1:0] cnt,
  input  logic          ien,
  output logic          match,
  output logic          irq
);
  logic [DW-1:0] buf_q, lat_q;
  logic          prev_eq_q, irq_q, eq;

  assign eq    = run && (cnt == lat_q);
  assign match = eq && !prev_eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '1;
      lat_q     <= '1;
      prev_eq_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      prev_eq_q <= eq;
      irq_q     <= match && ien;
      if (wr) buf_q <= wdata;
      if (wr && (!run || unf)) lat_q <= wdata;
      else if (unf)            lat_q <= buf_q;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/ocu_chan.sv
module ocu_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr,
  input  logic [DW-1:0] wdata,
  input  logic          src,
  input  logic [DW-1:0] cnt0,
  input  logic [DW-1:0] cnt1,
  input  logic [1:0]    run,
  input  logic [1:0]    unf,
  input  logic          trig,
  input  logic [1:0]    ien,
  output logic          wave,
  output logic [1:0]    irq,
  output logic          m_set,
  output logic          m_clr
);
  import ocu_pkg::*;

  logic [DW-1:0] cnt_sel;
  logic          run_sel, unf_sel, wave_q;
  logic [1:0]    mt;

  always_comb begin
    if (src_e'(src) == SRC_T1) begin
      cnt_sel = cnt1;
      run_sel = run[1];
      unf_sel = unf[1];
    end else begin
      cnt_sel = cnt0;
      run_sel = run[0];
      unf_sel = unf[0];
    end
  end

  for (genvar k = 0; k < LATCHES_PER_CH; k++) begin : g_slot
    ocu_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr(wr[k]), .wdata(wdata),
      .run(run_sel), .unf(unf_sel), .cnt(cnt_sel), .ien(ien[k]),
      .match(mt[k]), .irq(irq[k])
    );
  end

  assign m_set = mt[SET_IDX];
  assign m_clr = mt[CLR_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wave_q <= 1'b0;
    else if (trig && m_clr)  wave_q <= 1'b0;
    else if (trig && m_set)  wave_q <= 1'b1;
  end

  assign wave = wave_q;
endmodule

// File: rtl/ocu_top.sv
module ocu_top #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = $clog2(2 * NCH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    tmr0_cnt,
  input  logic [DW-1:0]    tmr1_cnt,
  input  logic [1:0]       tmr_run,
  input  logic [1:0]       tmr_unf,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [NCH-1:0]   wave_o,
  output logic [2*NCH-1:0] irq_o
);
  localparam int NSLOT = 2 * NCH;

  logic [NSLOT-1:0] cmp_we, ien_q;
  logic [NCH-1:0]   src_sel, trig_en, m_set, m_clr;

  ocu_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cmp_we(cmp_we), .src_sel(src_sel),
    .trig_en(trig_en), .ien(ien_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ocu_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr(cmp_we[2*c+1 -: 2]), .wdata(bus_wdata),
      .src(src_sel[c]), .cnt0(tmr0_cnt), .cnt1(tmr1_cnt),
      .run(tmr_run), .unf(tmr_unf), .trig(trig_en[c]),
      .ien(ien_q[2*c+1 -: 2]), .wave(wave_o[c]), .irq(irq_o[2*c+1 -: 2]),
      .m_set(m_set[c]), .m_clr(m_clr[c])
    );
  end
endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   wave_o,
  input logic [2*NCH-1:0] irq_o,
  input logic [2*NCH-1:0] ien,
  input logic [NCH-1:0]   trig,
  input logic [NCH-1:0]   m_set,
  input logic [NCH-1:0]   m_clr
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(ien)) == '0); // R8

  AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & $past(irq_o)) == '0); // R6

  AST_PIN_FROZEN_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    ((wave_o ^ $past(wave_o)) & ~$past(trig)) == '0); // R7

  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_o & ~$past(wave_o) & ~$past(m_set)) == '0); // R5

  AST_CLEAR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(m_set & m_clr & trig) & wave_o) == '0); // R11
endmodule

bind ocu_top ocu_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wave_o(wave_o), .irq_o(irq_o),
  .ien(ien_q), .trig(trig_en), .m_set(m_set), .m_clr(m_clr)
);

// File: tb/ocu_top_tb.sv
module ocu_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] c0 = '0, c1 = '0;
  logic [1:0] run = '0, unf = '0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] wave;
  logic [7:0] irq;

  logic       nx_we = 1'b0;
  logic [3:0] nx_addr = '0;
  logic [7:0] nx_data = '0;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [3:0] w;
    logic [7:0] i;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ocu_top dut_i (
    .clk(clk), .rst_n(rst_n), .tmr0_cnt(c0), .tmr1_cnt(c1),
    .tmr_run(run), .tmr_unf(unf), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .wave_o(wave), .irq_o(irq)
  );

  // monitor: compare outputs against queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (wave !== e.w || irq !== e.i) begin
          bad++;
          $display("FAIL %s: wave=%b irq=%b expected wave=%b irq=%b",
                   e.tag, wave, irq, e.w, e.i);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    nx_we = 1'b1; nx_addr = a; nx_data = d;
  endtask

  task automatic tick(input logic [7:0] a0, input logic [7:0] a1,
                      input logic [1:0] rn, input logic [1:0] uf,
                      input logic [3:0] ew, input logic [7:0] ei,
                      input string tg);
    exp_t e;
    @(negedge clk);
    c0 = a0; c1 = a1; run = rn; unf = uf;
    we = nx_we; addr = nx_addr; wdata = nx_data;
    nx_we = 1'b0;
    e.due = cyc + 1; e.w = ew; e.i = ei; e.tag = tg;
    sb.push_back(e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (wave !== 4'h0 || irq !== 8'h00) begin
      bad++;
      $display("FAIL R1: in reset wave=%b irq=%b expected 0", wave, irq);
    end
    rst_n = 1'b1;
    tick(0, 0, 0, 0, 4'h0, 8'h00, "R1 after reset");
    tick(0, 0, 0, 0, 4'h0, 8'h00, "R1 after reset");
    // configuration with timers stopped
    wr(9, 8'hFF); tick(0, 0, 0, 0, 4'h0, 8'h00, "R8 setup");
    wr(8, 8'hF0); tick(0, 0, 0, 0, 4'h0, 8'h00, "R7 setup");
    wr(0, 8'd10); tick(0, 0, 0, 0, 4'h0, 8'h00, "R2 write set");
    wr(1, 8'd5);  tick(0, 0, 0, 0, 4'h0, 8'h00, "R2 write clr");
    // R2 / R5 / R6
    tick(10, 0, 1, 0, 4'h1, 8'h01, "R2 R5 set match");
    tick(10, 0, 1, 0, 4'h1, 8'h00, "R6 no repeat");
    tick(7,  0, 1, 0, 4'h1, 8'h00, "R6 idle");
    tick(5,  0, 1, 0, 4'h0, 8'h02, "R5 clr match");
    // R3 buffered write while running
    wr(0, 8'd8); tick(6, 0, 1, 0, 4'h0, 8'h00, "R3 write buffered");
    tick(10, 0, 1, 0, 4'h1, 8'h01, "R3 old value matches");
    tick(8,  0, 1, 0, 4'h1, 8'h00, "R3 new value not yet");
    tick(20, 0, 1, 1, 4'h1, 8'h00, "R3 underflow load");
    tick(5,  0, 1, 0, 4'h0, 8'h02, "R3 clr");
    tick(8,  0, 1, 0, 4'h1, 8'h01, "R3 new value matches");
    // R4 write together with underflow
    wr(1, 8'd3); tick(30, 0, 1, 1, 4'h1, 8'h00, "R4 write at underflow");
    tick(5, 0, 1, 0, 4'h1, 8'h00, "R4 old value gone");
    tick(3, 0, 1, 0, 4'h0, 8'h02, "R4 new value matches");
    // R7 trigger off
    wr(8, 8'hE0); tick(4, 0, 1, 0, 4'h0, 8'h00, "R7 disable");
    tick(8, 0, 1, 0, 4'h0, 8'h01, "R7 pin held irq fires");
    tick(3, 0, 1, 0, 4'h0, 8'h02, "R7 pin held irq fires");
    // R8 interrupt enable off
    wr(9, 8'hFC); tick(2, 0, 1, 0, 4'h0, 8'h00, "R8 mask");
    wr(8, 8'hF0); tick(2, 0, 1, 0, 4'h0, 8'h00, "R8 trig on");
    tick(8, 0, 1, 0, 4'h1, 8'h00, "R8 wave moves irq masked");
    // R10 channel 1 on timer 1
    wr(8, 8'hF2); tick(8, 0, 1, 0, 4'h1, 8'h00, "R10 select");
    wr(9, 8'hFF); tick(8, 0, 1, 0, 4'h1, 8'h00, "R10 unmask");
    wr(2, 8'd40); tick(8, 0, 1, 0, 4'h1, 8'h00, "R10 write set");
    wr(3, 8'd20); tick(8, 0, 1, 0, 4'h1, 8'h00, "R10 write clr");
    tick(40, 0,  3, 0, 4'h1, 8'h00, "R10 timer0 ignored by ch1");
    tick(40, 40, 3, 0, 4'h3, 8'h04, "R10 timer1 set");
    tick(40, 20, 3, 0, 4'h1, 8'h08, "R10 timer1 clr");
    // R9 unreachable clear value
    wr(1, 8'd200); tick(100, 20, 3, 1, 4'h1, 8'h00, "R9 load");
    tick(3, 20, 3, 0, 4'h1, 8'h00, "R9 fixed level");
    tick(8, 20, 3, 0, 4'h1, 8'h01, "R9 other latch fires");
    tick(3, 20, 3, 0, 4'h1, 8'h00, "R9 fixed level");
    // R11 equal values on channel 2
    wr(4, 8'd60); tick(90, 20, 3, 1, 4'h1, 8'h00, "R11 load set");
    wr(5, 8'd60); tick(90, 20, 3, 1, 4'h1, 8'h00, "R11 load clr");
    tick(60, 20, 3, 0, 4'h1, 8'h30, "R11 clear wins");
    tick(50, 20, 3, 0, 4'h1, 8'h00, "R11 after");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule